// File: doc/BRIEF.md
# Edge-Selectable Retriggerable One-Shot

This block is a clocked pulse stretcher. A single-bit trigger line, which may be asynchronous to the clock, passes through a synchroniser and an edge detector. An active edge drives the output into its active state for a programmed number of clock cycles, after which the output returns to rest without further action. A select pin chooses whether rising or falling trigger edges count. A mode pin chooses between two behaviours. In the first, edges that arrive during a pulse are dropped. In the second, each edge restarts the timing, so a burst of closely spaced edges gives one long pulse.

The output is provided both true and inverted, so either polarity can serve as the active level. A clear pin ends any pulse in progress on the next clock edge and blocks new triggers while it is held. All control pins are plain levels sampled on the clock. The trigger is the only input that is synchronised inside the block. There is no data stream and therefore no handshake.

Top module: `oneshot_pulse`

## Requirements
- R1: After reset, and whenever no active trigger edge occurs, `pulse_q` is 0 and `pulse_qn` is 1.
- R2: With `edge_sel`=0, a 0-to-1 change of `trig_in` first sampled on clock edge k makes `pulse_q` go high after clock edge k+2. It stays high for exactly `width_cyc` cycles. A 1-to-0 change starts no pulse.
- R3: With `edge_sel`=1, the same timing applies to 1-to-0 changes of `trig_in`, and 0-to-1 changes start no pulse.
- R4: A `width_cyc` value of 0 produces a pulse one cycle wide.
- R5: With `retrig_en`=0, an active edge detected while the pulse is high has no effect on the pulse's end time.
- R6: With `retrig_en`=1, each active edge detected during a pulse restarts the full width. With n edges spaced Tt cycles apart, where Tt < W, the pulse is (n-1)·Tt + W cycles wide.
- R7: If an active edge is detected in the last cycle of a pulse, then with `retrig_en`=1 the pulse continues with no low cycle for a further W cycles. With `retrig_en`=0 the pulse ends on time and the edge is dropped.
- R8: `clear`=1 sampled on a clock edge drives `pulse_q` low after that edge. Active edges detected while `clear` is 1 start no pulse.
- R9: `pulse_qn` is always the inverse of `pulse_q`.
- R10: A `trig_in` level that is held steady through reset is not taken as an edge once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Trigger line, may be asynchronous |
| edge_sel | input | 1 | 0: rising edges are active, 1: falling edges are active |
| retrig_en | input | 1 | 1: edges restart the timing during a pulse |
| width_cyc | input | CNT_W (16) | Pulse width in clock cycles; 0 is treated as 1 |
| clear | input | 1 | Ends the pulse and blocks triggers while it is 1 |
| pulse_q | output | 1 | True output, 1 while the pulse is active |
| pulse_qn | output | 1 | Complement of pulse_q |

## Verification
The bench targets the case where an edge arrives in the last active cycle. In that case a faulty design would leave a one-cycle gap in retrigger mode, or would start a second pulse in the other mode. It checks that edges arriving mid-pulse neither stretch a pulse in non-retrigger mode nor fail to stretch it in retrigger mode. A width of zero must give one cycle, not zero or 65536. It also checks that the opposite edge polarity is dropped, that a level held through reset produces no pulse, and that an edge arriving under clear does not start a pulse once clear is released.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_prev,
  output logic ready
);
  localparam int unsigned WARM = STAGES + 1;

  logic [STAGES-1:0] chain;
  logic              prev_r;
  logic [WARM-1:0]   warm;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_r <= 1'b0;
      warm   <= '0;
    end else begin
      prev_r <= chain[STAGES-1];
      warm   <= {warm[WARM-2:0], 1'b1};
    end
  end

  assign lvl      = chain[STAGES-1];
  assign lvl_prev = prev_r;
  assign ready    = warm[WARM-1];
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
  import oneshot_pkg::*;
(
  input  logic  lvl,
  input  logic  lvl_prev,
  input  logic  ready,
  input  edge_e sel,
  output logic  fire
);
  logic rise, fall;

  always_comb begin
    rise = lvl & ~lvl_prev;
    fall = ~lvl & lvl_prev;
    fire = 1'b0;
    if (ready) begin
      unique case (sel)
        EDGE_RISE: fire = rise;
        EDGE_FALL: fire = fall;
        default:   fire = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             clear,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] width,
  output logic             active
);
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] reload;
  logic             last;

  always_comb begin
    reload = (width == '0) ? '0 : width - 1'b1;
    last   = (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (clear) begin
      active <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      if (fire) begin
        active <= 1'b1;
        remain <= reload;
      end
    end else if (fire && retrig_en) begin
      remain <= reload;
    end else if (last) begin
      active <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             edge_sel,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] width_cyc,
  input  logic             clear,
  output logic             pulse_q,
  output logic             pulse_qn
);
  logic  lvl, lvl_prev, ready, fire, active;
  edge_e sel;

  assign sel = edge_e'(edge_sel);

  oneshot_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in),
    .lvl(lvl), .lvl_prev(lvl_prev), .ready(ready)
  );

  oneshot_edge u_edge (
    .lvl(lvl), .lvl_prev(lvl_prev), .ready(ready), .sel(sel), .fire(fire)
  );

  oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clear(clear),
    .retrig_en(retrig_en), .width(width_cyc), .active(active)
  );

  assign pulse_q  = active;
  assign pulse_qn = ~active;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk (
  input logic clk,
  input logic rst_n,
  input logic fire,
  input logic clear,
  input logic retrig_en,
  input logic pulse_q,
  input logic pulse_qn
);
  // R2
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pulse_q && !clear) |=> pulse_q);

  // R1
  rest_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !pulse_q) |=> !pulse_q);

  // R8
  clear_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pulse_q);

  // R7
  retrig_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && fire && retrig_en && !clear) |=> pulse_q);

  // R9
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_qn == !pulse_q);
endmodule

bind oneshot_pulse oneshot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .clear(clear),
  .retrig_en(retrig_en), .pulse_q(pulse_q), .pulse_qn(pulse_qn)
);

// File: tb/sim_oneshot_pulse.sv
`timescale 1ns/1ps
module sim_oneshot_pulse;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b1;
  logic        edge_sel = 1'b0;
  logic        retrig_en = 1'b0;
  logic [15:0] width_cyc = 16'd5;
  logic        clear = 1'b0;
  logic        pulse_q, pulse_qn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int qn_bad = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  typedef struct { int start; int len; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oneshot_pulse u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .edge_sel(edge_sel),
    .retrig_en(retrig_en), .width_cyc(width_cyc), .clear(clear),
    .pulse_q(pulse_q), .pulse_qn(pulse_qn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input int start, input int len, input string tag);
    exp_t e;
    e.start = start; e.len = len; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: measures each pulse and compares it with the scoreboard
  initial begin : monitor
    bit was_hi;
    int st;
    was_hi = 1'b0;
    st = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (pulse_qn !== ~pulse_q) qn_bad++;
        if (pulse_q && !was_hi) st = cyc;
        if (!pulse_q && was_hi) begin
          if (sb.size() == 0) begin
            check(1'b0, "unexpected pulse start", st, -1);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(st == e.start, {e.tag, " start"}, st, e.start);
            check((cyc - st) == e.len, {e.tag, " width"}, cyc - st, e.len);
          end
        end
        was_hi = pulse_q;
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int c;
    wait_cyc(3);
    check(pulse_q == 1'b0 && pulse_qn == 1'b1, "R1 reset state", pulse_q, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    wait_cyc(8);
    // R10: trig held high through reset gives no pulse
    check(pulse_q == 1'b0, "R10 held level after reset", pulse_q, 0);
    trig_in = 1'b0;
    wait_cyc(8);
    // R1: a falling edge in rising mode leaves the output at rest
    check(pulse_q == 1'b0 && pulse_qn == 1'b1, "R1 rest without active edge", pulse_q, 0);

    // R2: rising edge, width 5
    c = cyc; trig_in = 1'b1; push(c + 3, 5, "R2 rising");
    wait_cyc(10); trig_in = 1'b0; wait_cyc(10);

    // R3: falling mode
    edge_sel = 1'b1;
    wait_cyc(2);
    trig_in = 1'b1; wait_cyc(8);
    c = cyc; trig_in = 1'b0; push(c + 3, 5, "R3 falling");
    wait_cyc(10);
    edge_sel = 1'b0;
    wait_cyc(2);

    // R4: width 0 gives one cycle
    width_cyc = 16'd0;
    c = cyc; trig_in = 1'b1; push(c + 3, 1, "R4 zero width");
    wait_cyc(4); trig_in = 1'b0; wait_cyc(6);

    // R5: non-retrigger ignores mid-pulse edge
    width_cyc = 16'd8; retrig_en = 1'b0;
    c = cyc; trig_in = 1'b1; push(c + 3, 8, "R5 ignore mid-pulse");
    wait_cyc(2); trig_in = 1'b0;
    wait_cyc(2); trig_in = 1'b1;
    wait_cyc(2); trig_in = 1'b0;
    wait_cyc(15);

    // R6: three edges spaced 3 cycles, width 6 -> 2*3+6
    width_cyc = 16'd6; retrig_en = 1'b1;
    c = cyc; trig_in = 1'b1; push(c + 3, 12, "R6 retrigger stretch");
    wait_cyc(1); trig_in = 1'b0; wait_cyc(2); trig_in = 1'b1;
    wait_cyc(1); trig_in = 1'b0; wait_cyc(2); trig_in = 1'b1;
    wait_cyc(1); trig_in = 1'b0;
    wait_cyc(20);

    // R7: edge in the last active cycle, retrigger mode
    width_cyc = 16'd4; retrig_en = 1'b1;
    c = cyc; trig_in = 1'b1; push(c + 3, 8, "R7 retrig at expiry");
    wait_cyc(2); trig_in = 1'b0; wait_cyc(2); trig_in = 1'b1;
    wait_cyc(2); trig_in = 1'b0;
    wait_cyc(15);

    // R7: same stimulus, non-retrigger mode drops the edge
    retrig_en = 1'b0;
    c = cyc; trig_in = 1'b1; push(c + 3, 4, "R7 nonretrig at expiry");
    wait_cyc(2); trig_in = 1'b0; wait_cyc(2); trig_in = 1'b1;
    wait_cyc(2); trig_in = 1'b0;
    wait_cyc(15);

    // R8: clear cuts the pulse and blocks edges while held
    width_cyc = 16'd10;
    c = cyc; trig_in = 1'b1; push(c + 3, 3, "R8 clear cut");
    wait_cyc(5); clear = 1'b1;
    wait_cyc(1); trig_in = 1'b0;
    wait_cyc(2); trig_in = 1'b1;
    wait_cyc(4); clear = 1'b0;
    wait_cyc(15);
    check(pulse_q == 1'b0, "R8 edge under clear ignored", pulse_q, 0);

    check(sb.size() == 0, "R2 all expected pulses seen", sb.size(), 0);
    check(qn_bad == 0, "R9 complement output", qn_bad, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule